// File: doc/BRIEF.md
# Port-Mapped Hardware Multiplier

This block gives an 8-bit soft processor without a multiply instruction access to unsigned multiplication. It sits on the processor's byte-wide port bus. Operand bytes arrive through OUTPUT transfers to decoded port addresses. Product bytes are read back through INPUT transfers. A mode bit chooses one of two modes: a narrow 8x8 multiply with a 16-bit result, or a wide multiply of operands `OPND_BYTES` bytes each, which is 16x16 with a 32-bit result at the defaults.

Every write to an operand byte or to the mode register sets off a registered recompute of the product on the next clock. The processor takes two clocks per instruction, so an INPUT in the instruction right after the last OUTPUT always returns the new product. When no product port is being read, the read-data output is zero. This lets the block share the input bus with other peripherals through a plain OR.

Top module: `port_mult_unit`

## Requirements
- R1: After reset, all operand bytes, the mode bit and the product are zero. Every product port reads 0x00 and the mode is narrow.
- R2: A write with wr_stb_i high captures out_port_i on the rising clock edge when port_id_i matches an operand address. The operand addresses are OPND_BASE+0 (A low), +1 (A high), +2 (B low) and +3 (B high). A write to any other address leaves the operands unchanged.
- R3: The mode register is at OPND_BASE+4, and bit 0 selects the mode (1 = wide, 0 = narrow). In narrow mode the product is A[7:0]*B[7:0]. The upper product bytes read zero, and the high operand bytes have no effect on the result but stay stored.
- R4: In wide mode the product is the full unsigned 32-bit value A*B.
- R5: The product register loads on the rising edge that follows the edge that captured an operand or mode write. A read between those two edges returns the previous product.
- R6: The product changes only in the cycle after an operand or mode write.
- R7: While rd_stb_i is high, reading PROD_BASE+k returns product byte k combinationally, least significant byte first (k = 0..3).
- R8: in_port_o is 0x00 whenever rd_stb_i is low or port_id_i matches no product port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_id_i | input | 8 | Port address of the current transfer |
| out_port_i | input | 8 | Write data from the processor |
| wr_stb_i | input | 1 | Write strobe, one cycle |
| rd_stb_i | input | 1 | Read strobe |
| in_port_o | output | 8 | Read data, zero when not selected |

## Verification
An operand byte is stored on the edge that samples its write strobe, and the product is due one edge later. The bench reads a product port half a cycle after the capturing edge and expects the old value there. It reads again half a cycle after the next edge and expects the new value. Read data is combinational, so each read samples 1 ns after its address and strobe are driven on a falling edge, and checks the value in the same cycle. Random operand pairs in both modes are mixed with directed extremes, mode switches and writes to unused addresses.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t addr_add(input byte_t base, input int unsigned off);
    return byte_t'(base + byte_t'(off));
  endfunction
endpackage

// File: rtl/pm_port_decode.sv
module pm_port_decode
  import pm_pkg::*;
#(
  parameter byte_t       OPND_BASE  = 8'h40,
  parameter byte_t       PROD_BASE  = 8'h48,
  parameter int unsigned OPND_BYTES = 2,
  localparam int unsigned PB    = 2 * OPND_BYTES,
  localparam int unsigned SEL_W = $clog2(PB)
) (
  input  byte_t                  port_id_i,
  input  logic                   wr_stb_i,
  input  logic                   rd_stb_i,
  output logic [OPND_BYTES-1:0]  a_we_o,
  output logic [OPND_BYTES-1:0]  b_we_o,
  output logic                   ctrl_we_o,
  output logic                   load_o,
  output logic                   rd_hit_o,
  output logic [SEL_W-1:0]       rd_sel_o
);
  byte_t rd_off;

  for (genvar i = 0; i < OPND_BYTES; i++) begin : g_we
    localparam byte_t A_ADDR = addr_add(OPND_BASE, i);
    localparam byte_t B_ADDR = addr_add(OPND_BASE, OPND_BYTES + i);
    assign a_we_o[i] = wr_stb_i && (port_id_i == A_ADDR);
    assign b_we_o[i] = wr_stb_i && (port_id_i == B_ADDR);
  end

  localparam byte_t CTRL_ADDR = addr_add(OPND_BASE, 2 * OPND_BYTES);
  assign ctrl_we_o = wr_stb_i && (port_id_i == CTRL_ADDR);
  assign load_o    = ctrl_we_o || (|a_we_o) || (|b_we_o);

  assign rd_off   = byte_t'(port_id_i - PROD_BASE);
  assign rd_hit_o = rd_stb_i && (rd_off < byte_t'(PB));
  assign rd_sel_o = rd_off[SEL_W-1:0];
endmodule

// File: rtl/pm_opnd_bank.sv
module pm_opnd_bank
  import pm_pkg::*;
#(
  parameter int unsigned OPND_BYTES = 2,
  localparam int unsigned W = OPND_BYTES * BYTE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [OPND_BYTES-1:0] we_i,
  input  byte_t                 wdata_i,
  output logic [W-1:0]          q_o
);
  for (genvar i = 0; i < OPND_BYTES; i++) begin : g_byte
    byte_t byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= '0;
      else if (we_i[i]) byte_q <= wdata_i;
    end
    assign q_o[i*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/pm_mul_core.sv
module pm_mul_core
  import pm_pkg::*;
#(
  parameter int unsigned OPND_BYTES = 2,
  localparam int unsigned W  = OPND_BYTES * BYTE_W,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          wide_i,
  input  logic          load_i,
  output logic [PW-1:0] prod_o
);
  logic          pend_q;
  logic [PW-1:0] prod_q;
  logic [PW-1:0] wide_res;
  logic [2*BYTE_W-1:0] narrow_res;

  assign wide_res   = PW'(a_i) * PW'(b_i);
  assign narrow_res = (2*BYTE_W)'(a_i[BYTE_W-1:0]) * (2*BYTE_W)'(b_i[BYTE_W-1:0]);

  // recompute one edge after any operand/mode capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      prod_q <= '0;
    end else begin
      pend_q <= load_i;
      if (pend_q) prod_q <= wide_i ? wide_res : PW'(narrow_res);
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
  import pm_pkg::*;
#(
  parameter int unsigned PB = 4,
  localparam int unsigned SEL_W = $clog2(PB)
) (
  input  logic [PB*BYTE_W-1:0] prod_i,
  input  logic                 hit_i,
  input  logic [SEL_W-1:0]     sel_i,
  output byte_t                data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < PB; k++) begin
      if (hit_i && (sel_i == SEL_W'(k))) data_o |= prod_i[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/port_mult_unit.sv
module port_mult_unit
  import pm_pkg::*;
#(
  parameter byte_t       OPND_BASE  = 8'h40,
  parameter byte_t       PROD_BASE  = 8'h48,
  parameter int unsigned OPND_BYTES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] port_id_i,
  input  logic [7:0] out_port_i,
  input  logic       wr_stb_i,
  input  logic       rd_stb_i,
  output logic [7:0] in_port_o
);
  localparam int unsigned W     = OPND_BYTES * BYTE_W;
  localparam int unsigned PB    = 2 * OPND_BYTES;
  localparam int unsigned SEL_W = $clog2(PB);

  logic [OPND_BYTES-1:0] a_we, b_we;
  logic                  ctrl_we, load, rd_hit;
  logic [SEL_W-1:0]      rd_sel;
  logic [W-1:0]          a_q, b_q;
  logic [2*W-1:0]        prod_q;
  logic                  wide_q;

  pm_port_decode #(
    .OPND_BASE(OPND_BASE), .PROD_BASE(PROD_BASE), .OPND_BYTES(OPND_BYTES)
  ) u_dec (
    .port_id_i(port_id_i), .wr_stb_i(wr_stb_i), .rd_stb_i(rd_stb_i),
    .a_we_o(a_we), .b_we_o(b_we), .ctrl_we_o(ctrl_we), .load_o(load),
    .rd_hit_o(rd_hit), .rd_sel_o(rd_sel)
  );

  pm_opnd_bank #(.OPND_BYTES(OPND_BYTES)) u_opa (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(a_we), .wdata_i(out_port_i), .q_o(a_q)
  );

  pm_opnd_bank #(.OPND_BYTES(OPND_BYTES)) u_opb (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(b_we), .wdata_i(out_port_i), .q_o(b_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wide_q <= 1'b0;
    else if (ctrl_we) wide_q <= out_port_i[0];
  end

  pm_mul_core #(.OPND_BYTES(OPND_BYTES)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_q), .b_i(b_q),
    .wide_i(wide_q), .load_i(load), .prod_o(prod_q)
  );

  pm_rd_mux #(.PB(PB)) u_mux (
    .prod_i(prod_q), .hit_i(rd_hit), .sel_i(rd_sel), .data_o(in_port_o)
  );
endmodule

// File: rtl/pm_mul_chk.sv
module pm_mul_chk #(
  parameter logic [7:0]  OPND_BASE  = 8'h40,
  parameter logic [7:0]  PROD_BASE  = 8'h48,
  parameter int unsigned OPND_BYTES = 2,
  localparam int unsigned W = OPND_BYTES * 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [7:0]   port_id_i,
  input logic [7:0]   out_port_i,
  input logic         wr_stb_i,
  input logic         rd_stb_i,
  input logic [7:0]   in_port_o,
  input logic [W-1:0] a_i,
  input logic [2*W-1:0] prod_i,
  input logic         wide_i
);
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |-> in_port_o == 8'h00);

  a_r2_alo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && port_id_i == OPND_BASE) |=> a_i[7:0] == $past(out_port_i));

  a_r3_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i ##1 !wide_i) |-> prod_i[2*W-1:16] == '0);

  a_r6_product_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |-> ##2 $stable(prod_i));

  a_r7_read_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && port_id_i == PROD_BASE) |-> in_port_o == prod_i[7:0]);
endmodule

bind port_mult_unit pm_mul_chk #(
  .OPND_BASE(OPND_BASE), .PROD_BASE(PROD_BASE), .OPND_BYTES(OPND_BYTES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_id_i(port_id_i), .out_port_i(out_port_i),
  .wr_stb_i(wr_stb_i), .rd_stb_i(rd_stb_i), .in_port_o(in_port_o),
  .a_i(a_q), .prod_i(prod_q), .wide_i(wide_q)
);

// File: tb/port_mult_unit_tb.sv
module port_mult_unit_tb_top;
  localparam logic [7:0] OB   = 8'h40;
  localparam logic [7:0] PBA  = 8'h48;
  localparam logic [7:0] CTRL = 8'h44;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port_id = 8'h00, out_port = 8'h00;
  logic       wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] in_port;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  port_mult_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .port_id_i(port_id), .out_port_i(out_port),
    .wr_stb_i(wr_stb), .rd_stb_i(rd_stb), .in_port_o(in_port)
  );

  function automatic logic [31:0] exp_prod(input logic [15:0] a, input logic [15:0] b,
                                            input bit wide);
    if (wide) return 32'(a) * 32'(b);
    return 32'(a[7:0]) * 32'(b[7:0]);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    port_id = addr; out_port = data; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] data);
    @(negedge clk);
    port_id = addr; rd_stb = 1'b1;
    #1 data = in_port;
    rd_stb = 1'b0;
  endtask

  task automatic rd_prod(output logic [31:0] p);
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(8'(PBA + 8'(k)), d);
      p[k*8 +: 8] = d;
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input bit wide);
    wr(CTRL, {7'd0, wide});
    wr(OB,        a[7:0]);
    wr(8'(OB + 1), a[15:8]);
    wr(8'(OB + 2), b[7:0]);
    wr(8'(OB + 3), b[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    logic [7:0]  d;
    logic [15:0] a, b;
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    rd_prod(p);
    chk("R1 reset product", p, 32'h0);

    // R4: wide directed extremes
    load(16'hFFFF, 16'hFFFF, 1'b1); rd_prod(p);
    chk("R4 wide max", p, exp_prod(16'hFFFF, 16'hFFFF, 1'b1));
    load(16'h0000, 16'hBEEF, 1'b1); rd_prod(p);
    chk("R4 wide zero", p, 32'h0);

    // R3: narrow uses low bytes only, upper product zero
    load(16'h12FF, 16'h3402, 1'b0); rd_prod(p);
    chk("R3 narrow low bytes", p, 32'h0000_01FE);
    load(16'hFFFF, 16'hFFFF, 1'b0); rd_prod(p);
    chk("R3 narrow max", p, 32'h0000_FE01);
    // R3: high bytes were stored; switching mode alone recomputes wide
    wr(CTRL, 8'h01); rd_prod(p);
    chk("R3 mode switch to wide", p, exp_prod(16'hFFFF, 16'hFFFF, 1'b1));

    // R2: write to unused address leaves operands alone
    load(16'h1234, 16'h5678, 1'b1);
    wr(8'(OB + 5), 8'hAA);
    wr(8'(OB + 7), 8'h55);
    wr(CTRL, 8'h01);
    rd_prod(p);
    chk("R2 unused address ignored", p, exp_prod(16'h1234, 16'h5678, 1'b1));

    // R5: read between capture and compute edges sees old product
    @(negedge clk);
    port_id = OB; out_port = 8'h00; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; port_id = PBA; rd_stb = 1'b1;
    #1 chk("R5 old value before compute edge", 32'(in_port), 32'(exp_prod(16'h1234, 16'h5678, 1'b1) & 32'hFF));
    @(negedge clk);
    #1 chk("R5 new value after compute edge", 32'(in_port), 32'(exp_prod(16'h1200, 16'h5678, 1'b1) & 32'hFF));
    rd_stb = 1'b0;

    // R6: product holds over idle cycles and reads
    repeat (5) @(negedge clk);
    rd_prod(p);
    chk("R6 product held", p, exp_prod(16'h1200, 16'h5678, 1'b1));

    // R8: strobe low or non-product address gives zero
    @(negedge clk);
    port_id = PBA; rd_stb = 1'b0;
    #1 chk("R8 no strobe zero", 32'(in_port), 32'h0);
    rd(8'(PBA + 4), d); chk("R8 above product ports", 32'(d), 32'h0);
    rd(8'(PBA - 1), d); chk("R8 below product ports", 32'(d), 32'h0);
    rd(OB, d);          chk("R8 operand address read", 32'(d), 32'h0);

    // R7/R4/R3: random pairs both modes, byte-ordered reads
    for (int i = 0; i < 60; i++) begin
      bit wide;
      a = 16'($urandom); b = 16'($urandom); wide = bit'($urandom & 1);
      load(a, b, wide);
      rd_prod(p);
      chk(wide ? "R7 R4 random wide" : "R7 R3 random narrow", p, exp_prod(a, b, wide));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule